// File: doc/BRIEF.md
# Microprogrammed Multiplier Sequencer

This block sequences a shift-add multiplier datapath from a small read-only control store instead of hand-derived next-state logic. A 3-bit address register selects one microword per clock. Each word carries four datapath strobes and a branch specification: a 2-bit condition selector and two 3-bit successor addresses. The selected condition picks the successor. When the condition is true the second successor is used. Otherwise, or when the selector means "unconditional", the first successor is used.

The sequencer reads three status inputs: a start request, the low bit of the multiplier register, and a zero flag from the iteration counter. It drives four strobes. The first clears the accumulator and presets the counter. The second adds the multiplicand into the accumulator. The third shifts the carry/accumulator/multiplier chain right and decrements the counter. The fourth clears the carry. The datapath registers themselves belong to the surrounding design and are not part of this block.

Top module: `mpc_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after its release, all four strobes are 0 (address 0, the idle word).
- R2: In idle with start_i = 0 the sequencer stays idle, and all strobes stay 0 on every following cycle.
- R3: In idle with start_i = 1, the cycle after the clock edge shows init_o = 1 and clr_c_o = 1, with load_o = 0 and shift_o = 0.
- R4: Selector encoding: 0 = unconditional (first successor), 1 = start_i, 2 = q0_i, 3 = zero_i. A true condition selects the second successor.
- R5: The test word that follows the init word drives no strobes. If q0_i = 1 it is followed by an add word, where only load_o = 1. If q0_i = 0 it goes straight to the shift word.
- R6: The shift word drives shift_o = 1 and clr_c_o = 1 only. After the add word, the shift word always follows.
- R7: In the shift word, zero_i = 1 returns the sequencer to idle. zero_i = 0 returns it to the test word, where all strobes are 0.
- R8: The init word branches unconditionally. Its successor is the test word whatever the values of start_i, q0_i and zero_i.
- R9: With an n-bit datapath, a multiply runs from the first init cycle to the last shift cycle in 1 + 2n + (number of 1 bits in the multiplier) cycles.
- R10: When coupled to a shift-add datapath, the sequence leaves the exact 2n-bit product of the two operands in the accumulator and multiplier registers.
- R11: Unused addresses 5 to 7 hold a word with no strobes and an unconditional branch to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| q0_i | input | 1 | Low bit of the multiplier register |
| zero_i | input | 1 | Iteration counter equals zero |
| init_o | output | 1 | Clear accumulator, preset counter |
| load_o | output | 1 | Add multiplicand into accumulator and carry |
| shift_o | output | 1 | Shift carry/accumulator/multiplier right, decrement counter |
| clr_c_o | output | 1 | Clear carry |

## Verification
The assertions take for granted that q0_i and zero_i are stable and meaningful in the test and shift words. They do not require this in the words whose selector ignores those inputs. The directed phase therefore deliberately drives contradictory values on every input during the init and add words, to show those inputs are ignored. The datapath phase derives q0_i and zero_i from a bench model of the shift-add registers. That model loads its operands only while the sequencer is idle, so the status inputs are always consistent with the data. No sequence of inputs on the ports can reach addresses 5 to 7. An immediate check on the control store contents covers them instead.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NCTRL  = 4;

  typedef enum logic [1:0] {
    SEL_NXT = 2'd0,
    SEL_G   = 2'd1,
    SEL_Q0  = 2'd2,
    SEL_Z   = 2'd3
  } sel_e;

  typedef logic [ADDR_W-1:0] addr_t;

  // ctrl bit order: [3] init, [2] load, [1] shift, [0] clear carry
  typedef struct packed {
    logic [NCTRL-1:0] ctrl;
    sel_e             sel;
    addr_t            nxt0;
    addr_t            nxt1;
  } uword_t;

  localparam addr_t A_IDLE = 3'd0;
  localparam addr_t A_INIT = 3'd1;
  localparam addr_t A_TEST = 3'd2;
  localparam addr_t A_ADD  = 3'd3;
  localparam addr_t A_SHF  = 3'd4;

  function automatic uword_t ucode(input addr_t a);
    uword_t w;
    case (a)
      A_IDLE:  w = '{ctrl: 4'b0000, sel: SEL_G,   nxt0: A_IDLE, nxt1: A_INIT};
      A_INIT:  w = '{ctrl: 4'b1001, sel: SEL_NXT, nxt0: A_TEST, nxt1: A_IDLE};
      A_TEST:  w = '{ctrl: 4'b0000, sel: SEL_Q0,  nxt0: A_SHF,  nxt1: A_ADD};
      A_ADD:   w = '{ctrl: 4'b0100, sel: SEL_NXT, nxt0: A_SHF,  nxt1: A_IDLE};
      A_SHF:   w = '{ctrl: 4'b0011, sel: SEL_Z,   nxt0: A_TEST, nxt1: A_IDLE};
      default: w = '{ctrl: 4'b0000, sel: SEL_NXT, nxt0: A_IDLE, nxt1: A_IDLE};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/mpc_rom.sv
module mpc_rom
  import mpc_pkg::*;
(
  input  addr_t  addr_i,
  output uword_t word_o
);
  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = ucode(addr_t'(i));
  end

  assign word_o = rom[addr_i];

  // R11: spare words are inert and return to idle
  always_comb begin
    for (int k = int'(A_SHF) + 1; k < DEPTH; k++) begin
      assert (rom[k].ctrl == '0 && rom[k].sel == SEL_NXT && rom[k].nxt0 == A_IDLE)
        else $error("p_spare_word_r11");
    end
  end
endmodule

// File: rtl/mpc_cond_mux.sv
module mpc_cond_mux
  import mpc_pkg::*;
(
  input  sel_e  sel_i,
  input  logic  g_i,
  input  logic  q0_i,
  input  logic  z_i,
  input  addr_t nxt0_i,
  input  addr_t nxt1_i,
  output addr_t next_o
);
  logic cond;

  always_comb begin
    unique case (sel_i)
      SEL_G:   cond = g_i;
      SEL_Q0:  cond = q0_i;
      SEL_Z:   cond = z_i;
      default: cond = 1'b0;
    endcase
  end

  assign next_o = cond ? nxt1_i : nxt0_i;
endmodule

// File: rtl/mpc_car.sv
module mpc_car
  import mpc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  addr_t d_i,
  output addr_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= A_IDLE;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/mpc_seq.sv
module mpc_seq
  import mpc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic q0_i,
  input  logic zero_i,
  output logic init_o,
  output logic load_o,
  output logic shift_o,
  output logic clr_c_o
);
  addr_t  car_q, car_d;
  uword_t word;

  mpc_car u_car (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (car_d),
    .q_o   (car_q)
  );

  mpc_rom u_rom (
    .addr_i(car_q),
    .word_o(word)
  );

  mpc_cond_mux u_mux (
    .sel_i (word.sel),
    .g_i   (start_i),
    .q0_i  (q0_i),
    .z_i   (zero_i),
    .nxt0_i(word.nxt0),
    .nxt1_i(word.nxt1),
    .next_o(car_d)
  );

  assign {init_o, load_o, shift_o, clr_c_o} = word.ctrl;

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_q == A_IDLE && !start_i) |=> (car_q == A_IDLE && !init_o && !load_o && !shift_o && !clr_c_o));
  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_q == A_IDLE && start_i) |=> (init_o && clr_c_o && !load_o && !shift_o));
  p_init_uncond_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> (car_q == A_TEST));
  p_add_branch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_q == A_TEST && q0_i) |=> (load_o && !shift_o && !init_o));
  p_skip_add_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_q == A_TEST && !q0_i) |=> (shift_o && clr_c_o));
  p_add_then_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (shift_o && clr_c_o && !load_o));
  p_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && zero_i) |=> (car_q == A_IDLE));
  p_loop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && !zero_i) |=> (car_q == A_TEST));
  p_strobe_mix_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({init_o, load_o, shift_o}) <= 1);
endmodule

// File: tb/mpc_seq_tb.sv
module mpc_seq_tb;
  localparam int N = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0, q0_drv = 1'b0, zero_drv = 1'b0, dp_mode = 1'b0;
  logic init_w, load_w, shift_w, clrc_w, q0_w, zero_w;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  // bench model of the shift-add datapath
  logic [N-1:0] a_r, q_r, b_r, a_in, b_in;
  logic         c_r, ld_ops = 1'b0;
  logic [$clog2(N)-1:0] p_r;

  always_ff @(posedge clk) begin
    if (ld_ops) begin b_r <= a_in; q_r <= b_in; end
    if (init_w) begin a_r <= '0; p_r <= ($clog2(N))'(N-1); end
    if (clrc_w) c_r <= 1'b0;
    if (load_w) {c_r, a_r} <= {1'b0, a_r} + {1'b0, b_r};
    if (shift_w) begin
      {a_r, q_r} <= {c_r, a_r, q_r[N-1:1]};
      p_r <= p_r - 1'b1;
    end
  end

  assign q0_w   = dp_mode ? q_r[0]    : q0_drv;
  assign zero_w = dp_mode ? (p_r == 0) : zero_drv;

  mpc_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .q0_i(q0_w), .zero_i(zero_w),
    .init_o(init_w), .load_o(load_w), .shift_o(shift_w), .clr_c_o(clrc_w)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] strobes();
    return {28'd0, init_w, load_w, shift_w, clrc_w};
  endfunction

  // scoreboard
  logic [2*N-1:0] exp_prod_q[$];
  int             exp_cyc_q[$];

  task automatic do_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    a_in = a; b_in = b; ld_ops = 1'b1;
    exp_prod_q.push_back((2*N)'(a) * (2*N)'(b));
    exp_cyc_q.push_back(1 + 2*N + $countones(b));
    @(negedge clk);
    ld_ops = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (exp_prod_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin : monitor
    int  cyc  = 0;
    bit  busy = 0, fin = 0;
    forever begin
      @(negedge clk);
      if (fin) begin
        chk("R10 product", {16'd0, a_r, q_r}, {16'd0, exp_prod_q.pop_front()});
        chk("R9 cycles", cyc, exp_cyc_q.pop_front());
        fin = 0;
      end
      if (dp_mode) begin
        if (init_w) begin busy = 1; cyc = 0; end
        if (busy) cyc++;
        if (busy && shift_w && zero_w) begin busy = 0; fin = 1; end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", strobes(), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", strobes(), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 idle hold", strobes(), 0);
    end
    // directed walk, inputs set at negedge for the next edge
    start = 1'b1; q0_drv = 1'b1; zero_drv = 1'b0;
    @(negedge clk);
    chk("R3 init word", strobes(), 32'b1001);
    start = 1'b1; q0_drv = 1'b1; zero_drv = 1'b1;   // all ignored by init (R8)
    @(negedge clk);
    chk("R8 init goes to test word", strobes(), 0);
    start = 1'b0; q0_drv = 1'b1; zero_drv = 1'b1;
    @(negedge clk);
    chk("R5 add word on q0=1", strobes(), 32'b0100);
    q0_drv = 1'b0; zero_drv = 1'b1; start = 1'b1;   // ignored by add word (R4)
    @(negedge clk);
    chk("R6 shift after add", strobes(), 32'b0011);
    start = 1'b0; zero_drv = 1'b0;
    @(negedge clk);
    chk("R7 loop to test word", strobes(), 0);
    q0_drv = 1'b0;
    @(negedge clk);
    chk("R5 skip add on q0=0", strobes(), 32'b0011);
    zero_drv = 1'b1;
    @(negedge clk);
    chk("R7 exit to idle", strobes(), 0);
    zero_drv = 1'b0; q0_drv = 1'b1;
    @(negedge clk);
    chk("R2 idle after exit", strobes(), 0);
    // datapath phase
    dp_mode = 1'b1;
    do_mul(8'd0, 8'd0);
    do_mul(8'd255, 8'd255);
    do_mul(8'd13, 8'd1);
    do_mul(8'd1, 8'd128);
    do_mul(8'd200, 8'd0);
    for (int i = 0; i < 40; i++) do_mul(N'($urandom), N'($urandom));
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule